// File: doc/BRIEF.md
# Split-Screen Display Address Sequencer

This block produces the display-memory fetch address for each scan line of a single-panel LCD controller. It can stack two independent images on one screen. Software programs four values through a small byte-wide register port with a 4-bit address: two base addresses, a 10-bit boundary count and a per-line stride. The upper band of the screen is fetched from the first base. Once the programmed number of lines has been shown, the sequencer jumps to the second base for the rest of the frame.

The panel timing logic drives two strobes into the block: one marks the start of a frame and one marks the end of each line. Register writes go to a host copy. A shadow set is loaded from that copy only at frame start, so a frame is never torn by a write partway through it. When the dual-panel input is high, the boundary is bypassed and the whole frame is fetched from the first base.

Top module: `split_addr_seq`

## Requirements
- R1: After reset, `fetch_addr` is 0, `screen_sel` is 0 and every register address reads 0.
- R2: Register map (byte read/write, reads are combinational on `reg_rdata`):
  - 0x6 holds base A bits 7:0 and 0x7 holds bits 15:8.
  - 0x8 holds base B bits 7:0 and 0x9 holds bits 15:8.
  - 0xA holds the boundary count bits 7:0.
  - 0xB holds count bits 9:8 in data bits 1:0; its bits 7:2 read 0.
  - 0xC holds the stride bits 7:0 and 0xD holds bits 15:8.
  - Every other address reads 0.
- R3: One cycle after a `frame_start` strobe, `fetch_addr` equals base A as last written and `screen_sel` is 0.
- R4: Within the upper band, each `line_end` adds the stride to `fetch_addr`, modulo 2^16.
- R5: With count value C, line C+1 of the frame (line 0 is the first line) starts at base B, and `screen_sel` becomes 1. Example: C = 0x020 gives 33 upper lines.
- R6: After the switch, each further `line_end` adds the stride to the address that began at base B.
- R7: When C is greater than or equal to the number of lines in the frame, every line of the frame is fetched from the upper band.
- R8: While `dual_panel` is 1, the count is ignored: no switch happens and the address keeps advancing from base A.
- R9: Register writes made during a frame do not change that frame's addresses. They take effect at the next `frame_start`.
- R10: If `frame_start` and `line_end` are high in the same cycle, `frame_start` wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| dual_panel | input | 1 | Dual-panel mode, which disables the split |
| frame_start | input | 1 | Frame start strobe |
| line_end | input | 1 | End-of-line strobe |
| fetch_addr | output | 16 | Start address of the current line |
| screen_sel | output | 1 | 0 = upper band, 1 = lower band |

## Verification
A corrupt line counter or a bad boundary compare shows up directly: the jump to base B lands one line early or late. The bench sweeps the count across every value from 0 to past the frame height, so an off-by-one appears on the first affected line. A stale or prematurely loaded shadow register changes the address on the line right after a mid-frame write, or leaves the following frame on old values. A wrong stride accumulator diverges from the arithmetic base-plus-k-times-stride prediction on the second line of a band.

// File: rtl/split_pkg.sv
package split_pkg;
    localparam int ADDR_W = 16;
    localparam int CNT_W  = 10;
    localparam int DATA_W = 8;
    localparam int CNT_HI_W = CNT_W - DATA_W;

    localparam logic [3:0] RA_A_LO   = 4'h6;
    localparam logic [3:0] RA_A_HI   = 4'h7;
    localparam logic [3:0] RA_B_LO   = 4'h8;
    localparam logic [3:0] RA_B_HI   = 4'h9;
    localparam logic [3:0] RA_CNT_LO = 4'hA;
    localparam logic [3:0] RA_CNT_HI = 4'hB;
    localparam logic [3:0] RA_STR_LO = 4'hC;
    localparam logic [3:0] RA_STR_HI = 4'hD;

    typedef struct packed {
        logic [ADDR_W-1:0] base_a;
        logic [ADDR_W-1:0] base_b;
        logic [ADDR_W-1:0] stride;
        logic [CNT_W-1:0]  bound;
    } cfg_t;
endpackage

// File: rtl/split_host_regs.sv
module split_host_regs
    import split_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [3:0]        addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output cfg_t              cfg
);
    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (we) begin
            case (addr)
                RA_A_LO:   cfg_d.base_a[7:0]        = wdata;
                RA_A_HI:   cfg_d.base_a[15:8]       = wdata;
                RA_B_LO:   cfg_d.base_b[7:0]        = wdata;
                RA_B_HI:   cfg_d.base_b[15:8]       = wdata;
                RA_CNT_LO: cfg_d.bound[7:0]         = wdata;
                RA_CNT_HI: cfg_d.bound[CNT_W-1:8]   = wdata[CNT_HI_W-1:0];
                RA_STR_LO: cfg_d.stride[7:0]        = wdata;
                RA_STR_HI: cfg_d.stride[15:8]       = wdata;
                default:   cfg_d = cfg_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    always_comb begin
        rdata = '0;
        case (addr)
            RA_A_LO:   rdata = cfg_q.base_a[7:0];
            RA_A_HI:   rdata = cfg_q.base_a[15:8];
            RA_B_LO:   rdata = cfg_q.base_b[7:0];
            RA_B_HI:   rdata = cfg_q.base_b[15:8];
            RA_CNT_LO: rdata = cfg_q.bound[7:0];
            RA_CNT_HI: rdata = {{(DATA_W-CNT_HI_W){1'b0}}, cfg_q.bound[CNT_W-1:8]};
            RA_STR_LO: rdata = cfg_q.stride[7:0];
            RA_STR_HI: rdata = cfg_q.stride[15:8];
            default:   rdata = '0;
        endcase
    end

    assign cfg = cfg_q;
endmodule

// File: rtl/split_line_seq.sv
module split_line_seq
    import split_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_start,
    input  logic              line_end,
    input  logic              dual_panel,
    input  cfg_t              live,
    output logic [ADDR_W-1:0] fetch_addr,
    output logic              screen_sel
);
    typedef struct packed {
        cfg_t              sh;
        logic [CNT_W-1:0]  lcnt;
        logic [ADDR_W-1:0] addr;
        logic              sel;
    } st_t;

    st_t st_d, st_q;
    logic at_bound;

    assign at_bound = !dual_panel && !st_q.sel && (st_q.lcnt == st_q.sh.bound);

    always_comb begin
        st_d = st_q;
        if (frame_start) begin
            st_d.sh   = live;
            st_d.lcnt = '0;
            st_d.addr = live.base_a;
            st_d.sel  = 1'b0;
        end else if (line_end) begin
            if (st_q.lcnt != {CNT_W{1'b1}})
                st_d.lcnt = st_q.lcnt + 1'b1;
            if (at_bound) begin
                st_d.sel  = 1'b1;
                st_d.addr = st_q.sh.base_b;
            end else begin
                st_d.addr = st_q.addr + st_q.sh.stride;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign fetch_addr = st_q.addr;
    assign screen_sel = st_q.sel;

    // R3
    frame_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> (st_q.addr == $past(live.base_a)) && !st_q.sel);

    // R5
    switch_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.sel) |-> $past(line_end && !frame_start && !dual_panel));

    // R6
    lower_stride_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (line_end && !frame_start && st_q.sel) |=>
            (st_q.addr == ADDR_W'($past(st_q.addr) + $past(st_q.sh.stride))));

    // R8
    dual_noswitch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dual_panel && !st_q.sel && !frame_start) |=> !st_q.sel);

    // R9
    shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> $stable(st_q.sh));
endmodule

// File: rtl/split_addr_seq.sv
module split_addr_seq
    import split_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_we,
    input  logic [3:0]  reg_addr,
    input  logic [7:0]  reg_wdata,
    output logic [7:0]  reg_rdata,
    input  logic        dual_panel,
    input  logic        frame_start,
    input  logic        line_end,
    output logic [15:0] fetch_addr,
    output logic        screen_sel
);
    cfg_t cfg_live;

    split_host_regs u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (reg_we),
        .addr  (reg_addr),
        .wdata (reg_wdata),
        .rdata (reg_rdata),
        .cfg   (cfg_live)
    );

    split_line_seq u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (frame_start),
        .line_end    (line_end),
        .dual_panel  (dual_panel),
        .live        (cfg_live),
        .fetch_addr  (fetch_addr),
        .screen_sel  (screen_sel)
    );
endmodule

// File: tb/tb_split_addr_seq.sv
`timescale 1ns/1ps
module tb_split_addr_seq;
    logic clk = 0, rst_n = 0;
    logic reg_we = 0;
    logic [3:0] reg_addr = 0;
    logic [7:0] reg_wdata = 0, reg_rdata;
    logic dual_panel = 0, frame_start = 0, line_end = 0;
    logic [15:0] fetch_addr;
    logic screen_sel;

    int checks = 0, fails = 0;
    bit done = 0;

    always #2 clk = ~clk;

    split_addr_seq dut (.*);

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk); reg_addr = a; reg_wdata = d; reg_we = 1;
        @(negedge clk); reg_we = 0;
    endtask

    task automatic rd_chk(input logic [3:0] a, input int exp, input string req);
        @(negedge clk); reg_addr = a; #1;
        chk(req, reg_rdata, exp);
    endtask

    task automatic set_cfg(input int a, input int b, input int st, input int c);
        wr(4'h6, a[7:0]);  wr(4'h7, a[15:8]);
        wr(4'h8, b[7:0]);  wr(4'h9, b[15:8]);
        wr(4'hC, st[7:0]); wr(4'hD, st[15:8]);
        wr(4'hA, c[7:0]);  wr(4'hB, {6'b0, c[9:8]});
    endtask

    // expected line start for line k, split after c+1 lines unless dual
    function automatic int exp_addr(int k, int a, int b, int st, int c, bit dual);
        if (dual || k <= c) return (a + k*st) & 16'hFFFF;
        return (b + (k-c-1)*st) & 16'hFFFF;
    endfunction

    function automatic int exp_sel(int k, int c, bit dual);
        return (!dual && k > c) ? 1 : 0;
    endfunction

    task automatic pulse(input bit fs, input bit le);
        @(negedge clk); frame_start = fs; line_end = le;
        @(negedge clk); frame_start = 0; line_end = 0;
    endtask

    task automatic line_chk(int k, int a, int b, int st, int c, bit dual, int nl);
        string req;
        if (k == 0) req = "R3";
        else if (dual) req = "R8";
        else if (c >= nl) req = "R7";
        else if (k <= c) req = "R4";
        else if (k == c+1) req = "R5";
        else req = "R6";
        chk(req, fetch_addr, exp_addr(k, a, b, st, c, dual));
        chk(req, screen_sel, exp_sel(k, c, dual));
    endtask

    task automatic run_frame(int a, int b, int st, int c, bit dual, int nl);
        pulse(1, 0);
        line_chk(0, a, b, st, c, dual, nl);
        for (int k = 1; k < nl; k++) begin
            pulse(0, 1);
            line_chk(k, a, b, st, c, dual, nl);
        end
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        #7 rst_n = 1;
        // R1 reset state
        @(negedge clk);
        chk("R1", fetch_addr, 0);
        chk("R1", screen_sel, 0);
        for (int i = 0; i < 16; i++) rd_chk(i[3:0], 0, "R1");

        // R2 readback, including masked count MSB and unmapped addresses
        set_cfg(16'hA55A, 16'h1234, 16'h00F0, 10'h2C7);
        wr(4'hB, 8'hFF);
        rd_chk(4'h6, 8'h5A, "R2"); rd_chk(4'h7, 8'hA5, "R2");
        rd_chk(4'h8, 8'h34, "R2"); rd_chk(4'h9, 8'h12, "R2");
        rd_chk(4'hA, 8'hC7, "R2"); rd_chk(4'hB, 8'h03, "R2");
        rd_chk(4'hC, 8'hF0, "R2"); rd_chk(4'hD, 8'h00, "R2");
        rd_chk(4'h0, 0, "R2"); rd_chk(4'h5, 0, "R2");
        rd_chk(4'hE, 0, "R2"); rd_chk(4'hF, 0, "R2");

        // R4 R5 R6 R7: sweep the boundary across and beyond a 12-line frame
        for (int c = 0; c <= 14; c++) begin
            set_cfg(16'h1000, 16'h8000, 3, c);
            run_frame(16'h1000, 16'h8000, 3, c, 0, 12);
        end
        // large count via MSB field (R7)
        set_cfg(16'h0200, 16'h4000, 16'h0028, 10'h300);
        run_frame(16'h0200, 16'h4000, 16'h0028, 10'h300, 0, 12);
        // stride wrap modulo 2^16 (R4, R6)
        set_cfg(16'hFFF8, 16'hFFFC, 16'hFFF0, 4);
        run_frame(16'hFFF8, 16'hFFFC, 16'hFFF0, 4, 0, 12);

        // R8 dual-panel disables split
        dual_panel = 1;
        for (int c = 0; c <= 3; c++) begin
            set_cfg(16'h2000, 16'h9000, 5, c);
            run_frame(16'h2000, 16'h9000, 5, c, 1, 12);
        end
        dual_panel = 0;

        // R9 mid-frame writes deferred to next frame
        set_cfg(16'h1000, 16'h8000, 4, 2);
        pulse(1, 0);
        chk("R9", fetch_addr, 16'h1000);
        pulse(0, 1);
        set_cfg(16'h3000, 16'h6000, 7, 0);
        chk("R9", fetch_addr, 16'h1004);
        chk("R9", screen_sel, 0);
        for (int k = 2; k < 8; k++) begin
            pulse(0, 1);
            chk("R9", fetch_addr, exp_addr(k, 16'h1000, 16'h8000, 4, 2, 0));
            chk("R9", screen_sel, exp_sel(k, 2, 0));
        end
        run_frame(16'h3000, 16'h6000, 7, 0, 0, 6);

        // R10 frame_start beats a coincident line_end
        pulse(1, 1);
        chk("R10", fetch_addr, 16'h3000);
        chk("R10", screen_sel, 0);
        pulse(0, 1);
        chk("R10", fetch_addr, 16'h6000);
        chk("R10", screen_sel, 1);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule